// File: doc/BRIEF.md
# Decoded Memory-Mapped RAM Bank

This block is a 4096-byte read/write store that sits on the 16-bit address bus of an 8-bit processor. A page decoder looks at the top four address bits and the memory/IO qualifier. It enables the bank only for memory cycles that fall in the top 4K page, F000H to FFFFH. The twelve low address bits index the byte array directly.

Inside the selected page, the active-low read and write strobes are decoded to one of four cycle kinds: read, write, idle, or illegal. Illegal means both strobes are low. The shared data bus is modelled as three signals: an input byte, an output byte, and an output enable. The output enable is raised only for a legal read.

A write lands in the array on the rising clock edge. Read data appears combinationally in the same cycle. An illegal cycle changes no byte and sets a sticky error flag. Only a synchronous reset clears that flag.

Top module: `membank_top`

## Requirements
- R1: `cs_n` is 0 exactly when `addr[15:12]` equals 4'hF and `io_sel` is 0; otherwise it is 1.
- R2: The array has 4096 bytes indexed only by `addr[11:0]`. An access outside the page never alters a byte, including the byte at the same low offset.
- R3: With `cs_n`=0, `rd_n`=0 and `wr_n`=1, `data_oe` is 1 and `data_out` carries the stored byte at `addr[11:0]` in the same cycle.
- R4: In every other case, `data_oe` is 0 and `data_out` is 8'h00. This covers deselect, idle, write and illegal cycles.
- R5: With `cs_n`=0, `rd_n`=1 and `wr_n`=0, `data_in` is stored at `addr[11:0]` on the rising edge. A later read returns it.
- R6: An idle cycle leaves every stored byte unchanged. Idle means `cs_n`=0 with both strobes 1.
- R7: An illegal cycle (`cs_n`=0 with both strobes 0) stores nothing. It sets `err_flag` from the next rising edge, and the flag stays 1 until reset.
- R8: A cycle with `io_sel`=1 inside the page neither reads nor writes the bank.
- R9: While `rst_n` is 0 at a rising edge, `err_flag` becomes 0. Stored bytes are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and flag updates on rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | Processor address bus |
| io_sel | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_in | input | 8 | Byte arriving from the shared bus |
| data_out | output | 8 | Byte driven onto the shared bus; 0 when released |
| data_oe | output | 1 | Drive enable for `data_out` |
| cs_n | output | 1 | Decoded bank select, active low |
| err_flag | output | 1 | Sticky illegal-strobe indicator |

## Verification
The strobe decoder's write path and its illegal-cycle detection both react to a low write strobe inside the page. A cycle with both strobes low can therefore be mistaken for a write as well as being flagged. The bench provokes this deliberately, with a byte on `data_in` that differs from the stored one. It also provokes it randomly with independently drawn strobe bits.

Each such cycle passes only if three things hold. A read of that address afterwards returns the old byte from the bench's own model. `err_flag` is 1 one edge later. `data_oe` stayed 0 throughout.

// File: rtl/membank_pkg.sv
package membank_pkg;

    typedef enum logic [2:0] {
        CYC_OFF   = 3'd0,
        CYC_IDLE  = 3'd1,
        CYC_READ  = 3'd2,
        CYC_WRITE = 3'd3,
        CYC_BAD   = 3'd4
    } cyc_t;

    typedef struct packed {
        logic err;
    } errst_t;

endpackage

// File: rtl/membank_decode.sv
module membank_decode #(
    parameter int TAG_W = 4,
    parameter logic [TAG_W-1:0] PAGE_TAG = '1
) (
    input  logic [TAG_W-1:0] tag,
    input  logic             io_sel,
    output logic             sel_n
);
    always_comb begin
        sel_n = 1'b1;
        if (!io_sel && (tag == PAGE_TAG)) begin
            sel_n = 1'b0;
        end
    end
endmodule

// File: rtl/membank_ctrl.sv
module membank_ctrl
    import membank_pkg::*;
(
    input  logic sel_n,
    input  logic rd_n,
    input  logic wr_n,
    output cyc_t kind,
    output logic we,
    output logic oe,
    output logic bad
);
    always_comb begin
        if (sel_n) begin
            kind = CYC_OFF;
        end else begin
            unique case ({rd_n, wr_n})
                2'b11:   kind = CYC_IDLE;
                2'b01:   kind = CYC_READ;
                2'b10:   kind = CYC_WRITE;
                default: kind = CYC_BAD;
            endcase
        end
        we  = (kind == CYC_WRITE);
        oe  = (kind == CYC_READ);
        bad = (kind == CYC_BAD);
    end
endmodule

// File: rtl/membank_store.sv
module membank_store #(
    parameter int OFS_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << OFS_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[ofs] <= wdata;
        end
    end

    always_comb begin
        rdata = mem[ofs];
    end
endmodule

// File: rtl/membank_errtrk.sv
module membank_errtrk
    import membank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bad,
    output logic err
);
    errst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bad) begin
            st_d.err = 1'b1;
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign err = st_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && rst_n) |=> err) else $error("sticky flag dropped"); // R7
    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && rst_n) |=> err) else $error("illegal cycle not flagged"); // R7
    AST_ERR_RESET: assert property (@(posedge clk)
        !rst_n |=> !err) else $error("reset did not clear flag"); // R9
endmodule

// File: rtl/membank_top.sv
module membank_top
    import membank_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int OFS_W    = 12,
    parameter int DATA_W   = 8,
    parameter int PAGE_NUM = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_sel,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              cs_n,
    output logic              err_flag
);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam logic [TAG_W-1:0] PAGE_TAG = TAG_W'(PAGE_NUM);

    cyc_t              kind;
    logic              we, oe, bad;
    logic [DATA_W-1:0] rdata;

    membank_decode #(.TAG_W(TAG_W), .PAGE_TAG(PAGE_TAG)) u_decode (
        .tag    (addr[ADDR_W-1:OFS_W]),
        .io_sel (io_sel),
        .sel_n  (cs_n)
    );

    membank_ctrl u_ctrl (
        .sel_n (cs_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .kind  (kind),
        .we    (we),
        .oe    (oe),
        .bad   (bad)
    );

    membank_store #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (we),
        .ofs   (addr[OFS_W-1:0]),
        .wdata (data_in),
        .rdata (rdata)
    );

    membank_errtrk u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .bad   (bad),
        .err   (err_flag)
    );

    always_comb begin
        data_oe  = oe;
        data_out = oe ? rdata : '0;
    end

    AST_OE_LEGAL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!cs_n && !rd_n && wr_n)) else $error("bus driven outside read"); // R3
    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0)) else $error("released bus not zero"); // R4
    AST_IO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> (cs_n && !data_oe && !we)) else $error("io cycle touched bank"); // R8
    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_READ && $past(kind == CYC_WRITE) && addr == $past(addr))
        |-> (data_out == $past(data_in))) else $error("write not visible"); // R5
endmodule

// File: tb/sim_membank_top.sv
module sim_membank_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        io_sel = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  data_in = 8'h00;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        cs_n;
    logic        err_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [4096];
    logic       err_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    membank_top u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .io_sel(io_sel),
        .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .cs_n(cs_n), .err_flag(err_flag)
    );

    function automatic logic exp_cs_n(logic [15:0] a, logic io);
        return !((a[15:12] == 4'hF) && !io);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [15:0] a, logic io, logic rd, logic wr,
                         logic [7:0] d, string dtag);
        logic cse, oee;
        logic [7:0] de;
        @(negedge clk);
        addr = a; io_sel = io; rd_n = rd; wr_n = wr; data_in = d;
        #1;
        cse = exp_cs_n(a, io);
        oee = !cse && !rd && wr;
        de  = oee ? model[a[11:0]] : 8'h00;
        check(io ? "R8 cs_n" : "R1 cs_n", 32'(cs_n), 32'(cse));
        check(oee ? "R3 data_oe" : "R4 data_oe", 32'(data_oe), 32'(oee));
        check(dtag, 32'(data_out), 32'(de));
        @(posedge clk);
        if (!cse && rd && !wr) model[a[11:0]] = d;
        if (!cse && !rd && !wr) err_m = 1'b1;
        #1;
        check("R7 err_flag", 32'(err_flag), 32'(err_m));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; io_sel = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        err_m = 1'b0;
        check("R9 err_flag after reset", 32'(err_flag), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [15:0] a;
        logic io, rd, wr;
        void'($urandom(32'd4242));
        do_reset();
        check("R1 cs_n idle at reset", 32'(cs_n), 32'd1);
        check("R4 data_oe at reset", 32'(data_oe), 32'd0);

        // fill the whole page (R5)
        for (int i = 0; i < 4096; i++) begin
            apply(16'hF000 | 16'(i), 1'b0, 1'b1, 1'b0, 8'($urandom), "R5 fill");
        end

        // boundary reads (R3)
        apply(16'hF000, 1'b0, 1'b0, 1'b1, 8'h00, "R3 read F000");
        apply(16'hFFFF, 1'b0, 1'b0, 1'b1, 8'h00, "R3 read FFFF");
        apply(16'hEFFF, 1'b0, 1'b0, 1'b1, 8'h00, "R1 read EFFF deselected");

        // aliasing: write below the page must not hit same offset (R2)
        apply(16'hEFFF, 1'b0, 1'b1, 1'b0, ~model[12'hFFF], "R2 write EFFF");
        apply(16'h0FFF, 1'b0, 1'b1, 1'b0, ~model[12'hFFF], "R2 write 0FFF");
        apply(16'hFFFF, 1'b0, 1'b0, 1'b1, 8'h00, "R2 read FFFF unchanged");

        // io cycle inside page (R8)
        apply(16'hF010, 1'b1, 1'b1, 1'b0, ~model[12'h010], "R8 io write");
        apply(16'hF010, 1'b1, 1'b0, 1'b1, 8'h00, "R8 io read released");
        apply(16'hF010, 1'b0, 1'b0, 1'b1, 8'h00, "R8 content kept");

        // idle (R6)
        apply(16'hF011, 1'b0, 1'b1, 1'b1, ~model[12'h011], "R6 idle");
        apply(16'hF011, 1'b0, 1'b0, 1'b1, 8'h00, "R6 content kept");

        // write then immediate read (R5)
        apply(16'hF123, 1'b0, 1'b1, 1'b0, 8'hA5, "R5 write");
        apply(16'hF123, 1'b0, 1'b0, 1'b1, 8'h00, "R5 readback A5");

        // illegal cycle (R7)
        apply(16'hF020, 1'b0, 1'b0, 1'b0, ~model[12'h020], "R7 illegal bus released");
        apply(16'hF020, 1'b0, 1'b0, 1'b1, 8'h00, "R7 content kept");
        apply(16'hF021, 1'b0, 1'b1, 1'b1, 8'h00, "R7 idle, flag sticky");
        do_reset();
        apply(16'hF020, 1'b0, 1'b0, 1'b1, 8'h00, "R9 content kept over reset");
        apply(16'h1234, 1'b0, 1'b0, 1'b0, 8'h00, "R7 both low deselected");

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            a  = ($urandom % 2 == 0) ? (16'hF000 | 16'($urandom % 4096)) : 16'($urandom);
            io = ($urandom % 4 == 0);
            rd = 1'($urandom);
            wr = 1'($urandom);
            if (!rd && !wr && ($urandom % 3 != 0)) wr = 1'b1;
            apply(a, io, rd, wr, 8'($urandom), "R3/R4 random data_out");
            if ($urandom % 300 == 0) do_reset();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule